// File: doc/BRIEF.md
# Clock-Synchronous Burst Read Sequencer

This block serves the memory array of a parallel flash in clock-synchronous burst mode. When the host qualifies a cycle (chip select low, write strobe high, address strobe low) the block captures a start address, counts off a programmable initial latency, and then presents one array word per clock. Alongside the data it drives a ready flag, so the host knows on which cycles the data is valid. The array itself sits outside the block: the sequencer drives a word address `arr_addr` and expects the matching word on `arr_rdata` in the same cycle.

Bursts are 4 words, 8 words or unbounded. The fixed lengths wrap around inside their aligned block. An unbounded burst counts upward through the whole array, passes region boundaries and wraps from the top word to word zero. An unbounded burst that starts off a four-word boundary inserts a single wait cycle the first time it reaches such a boundary. The start address can come from either of two captures, whichever happens first: a clock edge that sees the address strobe low, or the strobe's rising edge when the strobe pulse was too short for any clock edge to see it.

Top module: `sync_burst_reader`

## Requirements
- R1: While `cfg_async_mode` is 1, no burst starts and `ready` stays 0. Synchronous bursts run only when it is 0.
- R2: A burst starts at a clock edge where `ce_n`=0, `we_n`=1 and `lat_n`=0. If `we_n`=0 at that edge, no burst starts. If `lat_n` stays low over several edges, the address is captured at the first of them only, and later changes on `addr` have no effect.
- R3: If `lat_n` goes low and back high between two clock edges, the address present at the rising edge of `lat_n` is used, and the burst starts at the next clock edge.
- R4: With latency value L in `cfg_lat` (0 acts as 1), `ready` is 0 after the capture edge and after the next L-1 edges. The first word is valid after the L-th edge following capture.
- R5: `cfg_len`=001 selects 4 words. The addresses run from the start address upward and wrap within the aligned four-word block (start 6 gives 6,7,4,5).
- R6: `cfg_len`=010 selects 8 words, which wrap within the aligned eight-word block. After the last word, `ready` returns to 0.
- R7: `cfg_len`=111, and every code other than 001 and 010, selects an unbounded burst. It increments by one word per clock through the whole array, passes region boundaries and wraps from the top address to 0.
- R8: An unbounded burst whose start address has bits [1:0] not equal to 00 shows exactly one cycle with `ready`=0 just before the first word whose address bits [1:0] are 00. After that it runs without gaps. An aligned start never stalls.
- R9: `ce_n`=1 stops the burst. `dq_en` and `ready` fall in the same cycle, and the burst does not resume when `ce_n` returns low.
- R10: `dq_en` is 1 exactly when `ce_n`=0 and `oe_n`=0. While `oe_n`=1 the burst keeps advancing, so the word shown after `oe_n` returns low is the one due in that cycle.
- R11: `ready`=1 only in a cycle where `dq` carries the array word of the burst position due in that cycle. `ready` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock internally |
| ce_n | input | 1 | Chip select, active low |
| lat_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output drive enable, active low |
| we_n | input | 1 | Write strobe, must be high for a read |
| addr | input | AW | Word address |
| cfg_async_mode | input | 1 | Configuration bit 15: 1 selects asynchronous reads, 0 selects bursts |
| cfg_len | input | 3 | Burst length code |
| cfg_lat | input | LATW | Initial latency in clocks |
| arr_addr | output | AW | Word address sent to the memory array |
| arr_rdata | input | DW | Array word for `arr_addr`, same cycle |
| dq | output | DW | Data toward the host |
| dq_en | output | 1 | Drive enable for `dq`; when it is 0 the data pins float |
| ready | output | 1 | Data-valid flag for the current cycle |

## Verification
The capture edge itself and the L-1 edges after it must show `ready` low. Word k is due after edge L+k, and each wait cycle adds one edge to the words that follow it. `dq_en`, and the fall of `ready` on `ce_n` or `oe_n`, are combinational, so they are due in the same cycle. The bench keeps one queue entry per clock edge, starting with the capture edge, and pops one entry 2 ns after every rising edge, once the registers have settled. It checks `ready` and `dq` against the entry at that moment. Strobe and enable changes are checked 1 ns after they are applied.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_BURST,
    ST_BUB
  } sbr_state_e;

  typedef enum logic [1:0] {
    BL_FOUR,
    BL_EIGHT,
    BL_CONT
  } sbr_len_e;

  function automatic sbr_len_e decode_len(input logic [2:0] code);
    case (code)
      3'b001:  return BL_FOUR;
      3'b010:  return BL_EIGHT;
      default: return BL_CONT;
    endcase
  endfunction

endpackage

// File: rtl/sbr_latch.sv
module sbr_latch #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          sync_en,
  input  logic [AW-1:0] addr,
  output logic          start,
  output logic [AW-1:0] start_addr
);

  // Strobe-domain capture: taken on every rising edge of lat_n
  logic [AW-1:0] hold_q;
  logic          tgl_q;

  always_ff @(posedge lat_n or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      hold_q <= addr;
      tgl_q  <= ~tgl_q;
    end
  end

  // Clock-domain view
  logic ack_q, ack_d;
  logic low_q, low_d;
  logic qual, pulse, edge_low, short_hit;

  always_comb begin
    qual      = !ce_n && we_n && sync_en;
    pulse     = tgl_q ^ ack_q;
    edge_low  = !lat_n && !low_q;
    short_hit = pulse && !low_q;
    start     = qual && (edge_low || short_hit);
    start_addr = short_hit ? hold_q : addr;
    ack_d     = tgl_q;
    low_d     = !lat_n && qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      low_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      low_q <= low_d;
    end
  end

endmodule

// File: rtl/sbr_addrgen.sv
module sbr_addrgen
  import sbr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] cur,
  input  sbr_len_e      mode,
  output logic [AW-1:0] nxt
);

  always_comb begin
    case (mode)
      BL_FOUR:  nxt = {cur[AW-1:2], cur[1:0] + 2'd1};
      BL_EIGHT: nxt = {cur[AW-1:3], cur[2:0] + 3'd1};
      default:  nxt = cur + AW'(1);
    endcase
  end

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int AW   = 12,
  parameter int LATW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [2:0]      len_code,
  input  logic [LATW-1:0] lat_cfg,
  output logic [AW-1:0]   cur_addr,
  output logic            word_valid,
  output logic            busy
);

  localparam int IW = 3;

  sbr_state_e      st_q, st_d;
  sbr_len_e        mode_q, mode_d;
  logic [LATW-1:0] cnt_q, cnt_d;
  logic [AW-1:0]   cur_q, cur_d, nxt;
  logic [IW-1:0]   idx_q, idx_d, idx_last;
  logic            unal_q, unal_d;

  sbr_addrgen #(.AW(AW)) u_gen (
    .cur  (cur_q),
    .mode (mode_q),
    .nxt  (nxt)
  );

  assign idx_last = (mode_q == BL_FOUR) ? IW'(3) : IW'(7);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    idx_d  = idx_q;
    unal_d = unal_q;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d   = ST_LAT;
      mode_d = decode_len(len_code);
      cnt_d  = (lat_cfg == '0) ? '0 : lat_cfg - LATW'(1);
      cur_d  = start_addr;
      idx_d  = '0;
      unal_d = (start_addr[1:0] != 2'b00);
    end else begin
      case (st_q)
        ST_LAT: begin
          if (cnt_q == '0) st_d = ST_BURST;
          else             cnt_d = cnt_q - LATW'(1);
        end
        ST_BURST: begin
          if (mode_q != BL_CONT && idx_q == idx_last) begin
            st_d = ST_IDLE;
          end else begin
            cur_d = nxt;
            idx_d = idx_q + IW'(1);
            if (mode_q == BL_CONT && unal_q && nxt[1:0] == 2'b00) begin
              st_d   = ST_BUB;
              unal_d = 1'b0;
            end
          end
        end
        ST_BUB:  st_d = ST_BURST;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= BL_FOUR;
      cnt_q  <= '0;
      cur_q  <= '0;
      idx_q  <= '0;
      unal_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
      idx_q  <= idx_d;
      unal_q <= unal_d;
    end
  end

  assign cur_addr   = cur_q;
  assign word_valid = (st_q == ST_BURST);
  assign busy       = (st_q != ST_IDLE);

  // R9
  ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (st_q == ST_IDLE));

  // R8
  bub_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUB && !ce_n && !start) |=> (st_q == ST_BURST));

  // R8
  bub_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUB) |-> (cur_q[1:0] == 2'b00));

  // R5
  fixed_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST && mode_q != BL_CONT && !ce_n && !start)
      |=> (cur_q[AW-1:3] == $past(cur_q[AW-1:3])));

endmodule

// File: rtl/sync_burst_reader.sv
module sync_burst_reader #(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int LATW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            lat_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic [AW-1:0]   addr,
  input  logic            cfg_async_mode,
  input  logic [2:0]      cfg_len,
  input  logic [LATW-1:0] cfg_lat,
  output logic [AW-1:0]   arr_addr,
  input  logic [DW-1:0]   arr_rdata,
  output logic [DW-1:0]   dq,
  output logic            dq_en,
  output logic            ready
);

  // Reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic          start;
  logic [AW-1:0] start_addr;
  logic          word_valid;
  logic          busy;

  sbr_latch #(.AW(AW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lat_n      (lat_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .sync_en    (!cfg_async_mode),
    .addr       (addr),
    .start      (start),
    .start_addr (start_addr)
  );

  sbr_ctrl #(.AW(AW), .LATW(LATW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ce_n       (ce_n),
    .start      (start),
    .start_addr (start_addr),
    .len_code   (cfg_len),
    .lat_cfg    (cfg_lat),
    .cur_addr   (arr_addr),
    .word_valid (word_valid),
    .busy       (busy)
  );

  assign dq_en = !ce_n && !oe_n;
  assign dq    = arr_rdata;
  assign ready = dq_en && word_valid;

  // R1
  async_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_async_mode && !busy) |=> !busy);

endmodule

// File: tb/tb_sync_burst_reader.sv
`timescale 1ns/1ps
module tb_sync_burst_reader;
  localparam int AW = 12, DW = 16, LATW = 4;

  logic clk, rst_n, ce_n, lat_n, oe_n, we_n, cfg_async_mode;
  logic [AW-1:0] addr, arr_addr;
  logic [2:0] cfg_len;
  logic [LATW-1:0] cfg_lat;
  logic [DW-1:0] arr_rdata, dq;
  logic dq_en, ready;

  int checks = 0;
  int errs = 0;
  logic [AW:0] q[$];

  function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
    return {a ^ 12'hA53, a[3:0] + 4'd7};
  endfunction

  assign arr_rdata = memv(arr_addr);

  sync_burst_reader #(.AW(AW), .DW(DW), .LATW(LATW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lat_n(lat_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .cfg_async_mode(cfg_async_mode),
    .cfg_len(cfg_len), .cfg_lat(cfg_lat), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .dq(dq), .dq_en(dq_en), .ready(ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input string req);
    logic [AW:0] e;
    bit er;
    @(posedge clk);
    #2;
    e = (q.size() > 0) ? q.pop_front() : '0;
    er = e[AW] && !ce_n && !oe_n;
    chk(ready === er, req, ready, er);
    if (er) chk(dq === memv(e[AW-1:0]), req, dq, memv(e[AW-1:0]));
    chk(dq_en === (!ce_n && !oe_n), "R10", dq_en, !ce_n && !oe_n);
  endtask

  task automatic build(input logic [AW-1:0] base, input logic [2:0] code, input int lat);
    int le;
    int n;
    logic [AW-1:0] a;
    bit un;
    le = (lat == 0) ? 1 : lat;
    q.delete();
    q.push_back('0);
    for (int i = 1; i < le; i++) q.push_back('0);
    if (code == 3'b001 || code == 3'b010) begin
      n = (code == 3'b001) ? 4 : 8;
      for (int i = 0; i < n; i++) begin
        a = (base & ~AW'(n - 1)) | ((base + AW'(i)) & AW'(n - 1));
        q.push_back({1'b1, a});
      end
    end else begin
      a = base;
      un = (base[1:0] != 2'b00);
      for (int k = 0; k < 40; k++) begin
        q.push_back({1'b1, a});
        a = a + AW'(1);
        if (un && a[1:0] == 2'b00) begin
          q.push_back('0);
          un = 1'b0;
        end
      end
    end
  endtask

  task automatic start_burst(input logic [AW-1:0] base, input logic [2:0] code,
                             input int lat, input string req);
    cfg_len = code;
    cfg_lat = LATW'(lat);
    addr = base;
    lat_n = 1'b0;
    build(base, code, lat);
    tick(req);
    lat_n = 1'b1;
    addr = ~base;
  endtask

  task automatic end_by_ce(input string req);
    ce_n = 1'b1;
    #1;
    chk(dq_en === 1'b0, req, dq_en, 0);
    chk(ready === 1'b0, req, ready, 0);
    q.delete();
    tick(req);
    tick(req);
    ce_n = 1'b0;
    tick(req);
    tick(req);
  endtask

  initial begin
    #2_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; lat_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; cfg_async_mode = 1'b0; cfg_len = 3'b001; cfg_lat = 4'd2;
    #23 rst_n = 1'b1;
    // R11 reset state
    repeat (3) tick("R11");
    ce_n = 1'b0; oe_n = 1'b0;
    tick("R11");

    // R5 / R4: four-word wrap, latency 3
    start_burst(12'h006, 3'b001, 3, "R5");
    repeat (7) tick("R5");

    // R6: eight-word wrap, then ready low
    start_burst(12'h00D, 3'b010, 2, "R6");
    repeat (10) tick("R6");

    // R4: latency 0 acts as 1, and a long latency
    start_burst(12'h020, 3'b001, 0, "R4");
    repeat (5) tick("R4");
    start_burst(12'h040, 3'b001, 9, "R4");
    repeat (13) tick("R4");

    // R8: unaligned unbounded burst, one stall
    start_burst(12'h103, 3'b111, 2, "R8");
    repeat (12) tick("R8");
    end_by_ce("R9");

    // R8: aligned unbounded burst, no stall
    start_burst(12'h104, 3'b111, 1, "R8");
    repeat (10) tick("R8");
    end_by_ce("R9");

    // R7: other code acts as unbounded, wraps at array top
    start_burst(12'hFFE, 3'b011, 2, "R7");
    repeat (8) tick("R7");
    end_by_ce("R9");
    // R7: aligned run across a region boundary
    start_burst(12'h3FC, 3'b111, 2, "R7");
    repeat (10) tick("R7");
    end_by_ce("R9");

    // R10: burst keeps advancing while outputs are off
    start_burst(12'h200, 3'b010, 2, "R10");
    repeat (2) tick("R10");
    oe_n = 1'b1;
    #1;
    chk(dq_en === 1'b0, "R10", dq_en, 0);
    chk(ready === 1'b0, "R10", ready, 0);
    repeat (3) tick("R10");
    oe_n = 1'b0;
    repeat (6) tick("R10");

    // R2: strobe held low, address captured once only
    cfg_len = 3'b001; cfg_lat = 4'd2;
    addr = 12'h300;
    lat_n = 1'b0;
    build(12'h300, 3'b001, 2);
    tick("R2");
    addr = 12'h555;
    repeat (6) tick("R2");
    lat_n = 1'b1;
    tick("R2");

    // R2: write strobe low blocks the start
    we_n = 1'b0;
    addr = 12'h010;
    lat_n = 1'b0;
    q.delete();
    tick("R2");
    lat_n = 1'b1;
    repeat (4) tick("R2");
    we_n = 1'b1;

    // R1: asynchronous mode blocks bursts
    cfg_async_mode = 1'b1;
    addr = 12'h010;
    lat_n = 1'b0;
    q.delete();
    tick("R1");
    lat_n = 1'b1;
    repeat (4) tick("R1");
    cfg_async_mode = 1'b0;
    tick("R1");

    // R3: short strobe pulse between edges
    cfg_len = 3'b001; cfg_lat = 4'd2;
    addr = 12'h0A5;
    lat_n = 1'b0;
    #3 lat_n = 1'b1;
    #1 addr = 12'h777;
    build(12'h0A5, 3'b001, 2);
    tick("R3");
    repeat (6) tick("R3");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule